// File: doc/BRIEF.md
# Paired Carryless 16x64 Multiplier

This block forms the GF(2) sum of two carryless polynomial products in a single step. A 128-bit data word is cut into two 64-bit halves. Each half is multiplied without carries by its own 16-bit constant, and the two products are XORed into one 80-bit result. A folding datapath uses it to advance a 128-bit remainder across a span of input: each half is multiplied by a precomputed constant, and the combined result is then merged with fresh data.

The only multiplier in the datapath is an 8-bit by 8-bit carryless cell with a 16-bit result. Each constant is split into its low and high byte. Each 64-bit half is split into its even-numbered bytes and its odd-numbered bytes. Each byte of a constant then multiplies each lane group. The low-byte-by-odd-lane and high-byte-by-even-lane products sit at the same byte rank, so one XOR merges them before anything is shifted. The products of the two halves are merged lane by lane before the rank shifts, so a single shift network serves both halves. The result is registered, which gives one cycle of latency. It is placed in the low bits of a 128-bit output bus, and the upper bits of that bus are zero.

Top module: `clmul16x64_pair`

## Requirements
- R1: One rising edge after the inputs are sampled, product[79:0] equals the carryless product of k_lo and data[63:0], XORed with the carryless product of k_hi and data[127:64]. Bit i of every operand is the coefficient of x^i.
- R2: product[127:80] is always zero.
- R3: The output changes only at a rising clock edge. Inputs that change between edges leave product unchanged until the next edge.
- R4: While rst_n is low, product is zero. The reset is asynchronous and acts without waiting for a clock edge.
- R5: If both constants are zero, or if data is zero, product is zero one edge later.
- R6: A constant of 0x0001 passes its data half unchanged into product[63:0]. A constant of 0x0100 shifts its half left by 8 bit positions.
- R7: Each constant acts only on its own half. With k_hi zero the result does not depend on data[127:64], and with k_lo zero it does not depend on data[63:0].
- R8: product[79] is always zero. The highest reachable bit is bit 78, which is set by a constant with bit 15 set paired with a data half whose bit 63 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register loads on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low; clears the result |
| k_lo | input | 16 | Constant that multiplies data[63:0] |
| k_hi | input | 16 | Constant that multiplies data[127:64] |
| data | input | 128 | Two 64-bit operand halves |
| product | output | 128 | Bits 79:0 hold the XOR of both products; bits 127:80 are zero |

## Verification
Random constants and data words exercise every byte lane and every rank at the same time, and are compared with a bit-serial shift-and-XOR model. Directed patterns isolate single features. An identity constant and a byte-shift constant expose misplaced even or odd lanes and wrong rank offsets. All-ones operands drive every partial product at once and reveal a missing term in the shared middle-rank XOR. A top-degree pair tells a correct bound at bit 78 apart from an off-by-one shift. With one constant zeroed, a half that leaks into the wrong product or a swapped pairing of constants and halves shows up at once.

// File: rtl/clmul_pkg.sv
package clmul_pkg;

  localparam int BYTE_W = 8;
  localparam int PP_W   = 16;

  // carryless 8x8 product, shift-and-xor over the bits of b
  function automatic logic [PP_W-1:0] clmul8(input logic [BYTE_W-1:0] a,
                                             input logic [BYTE_W-1:0] b);
    logic [PP_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc ^= {{(PP_W-BYTE_W){1'b0}}, a} << i;
    end
    return acc;
  endfunction

endpackage

// File: rtl/gf2_mul8.sv
module gf2_mul8
  import clmul_pkg::*;
(
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] b,
  output logic [PP_W-1:0]   p
);
  assign p = clmul8(a, b);
endmodule

// File: rtl/lane_bank.sv
// One scalar byte times a group of lane bytes, one 8x8 cell per lane.
module lane_bank
  import clmul_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [BYTE_W-1:0]       scal,
  input  logic [LANES*BYTE_W-1:0] lanes,
  output logic [LANES*PP_W-1:0]   prods
);
  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_cell
      gf2_mul8 u_cell (
        .a (scal),
        .b (lanes[i*BYTE_W +: BYTE_W]),
        .p (prods[i*PP_W +: PP_W])
      );
    end
  endgenerate
endmodule

// File: rtl/rank_merge.sv
// Places merged lane products at their byte ranks:
// even lane i -> rank 2i, middle lane i -> rank 2i+1, odd-high lane i -> rank 2i+2.
module rank_merge
  import clmul_pkg::*;
#(
  parameter int LANES = 4,
  localparam int SUM_W = PP_W*LANES + PP_W
) (
  input  logic [LANES*PP_W-1:0] lane_even,
  input  logic [LANES*PP_W-1:0] lane_mid,
  input  logic [LANES*PP_W-1:0] lane_odd,
  output logic [SUM_W-1:0]      sum
);
  always_comb begin
    logic [SUM_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < LANES; i++) begin
      acc ^= SUM_W'(lane_even[i*PP_W +: PP_W]) << (PP_W*i);
      acc ^= SUM_W'(lane_mid[i*PP_W +: PP_W])  << (PP_W*i + BYTE_W);
      acc ^= SUM_W'(lane_odd[i*PP_W +: PP_W])  << (PP_W*i + PP_W);
    end
    sum = acc;
  end
endmodule

// File: rtl/clmul16x64_pair.sv
module clmul16x64_pair
  import clmul_pkg::*;
#(
  parameter int WIDE_BYTES = 8,
  parameter bit REGISTERED = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [15:0]                 k_lo,
  input  logic [15:0]                 k_hi,
  input  logic [2*8*WIDE_BYTES-1:0]   data,
  output logic [2*8*WIDE_BYTES-1:0]   product
);
  localparam int HALF_W    = BYTE_W*WIDE_BYTES;
  localparam int DATA_W    = 2*HALF_W;
  localparam int LANES     = WIDE_BYTES/2;
  localparam int LANE_BITS = LANES*BYTE_W;
  localparam int PP_BITS   = LANES*PP_W;
  localparam int SUM_W     = HALF_W + PP_W;

  logic [1:0][15:0]        k;
  logic [1:0][HALF_W-1:0]  half;
  logic [1:0][LANE_BITS-1:0] even_b, odd_b;
  // products: scalar byte (low/high) x lane group (even/odd), per half
  logic [1:0][PP_BITS-1:0] pp_le, pp_lo, pp_he, pp_ho;
  logic [PP_BITS-1:0]      lane_even, lane_mid, lane_odd;
  logic [SUM_W-1:0]        sum_w;
  logic [8*PP_BITS-1:0]    pp_all;

  assign k[0]    = k_lo;
  assign k[1]    = k_hi;
  assign half[0] = data[HALF_W-1:0];
  assign half[1] = data[DATA_W-1:HALF_W];

  genvar p, i;
  generate
    for (p = 0; p < 2; p++) begin : g_half
      for (i = 0; i < LANES; i++) begin : g_split
        assign even_b[p][i*BYTE_W +: BYTE_W] = half[p][2*i*BYTE_W +: BYTE_W];
        assign odd_b[p][i*BYTE_W +: BYTE_W]  = half[p][(2*i+1)*BYTE_W +: BYTE_W];
      end
      lane_bank #(.LANES(LANES)) u_le (.scal(k[p][7:0]),  .lanes(even_b[p]), .prods(pp_le[p]));
      lane_bank #(.LANES(LANES)) u_lo (.scal(k[p][7:0]),  .lanes(odd_b[p]),  .prods(pp_lo[p]));
      lane_bank #(.LANES(LANES)) u_he (.scal(k[p][15:8]), .lanes(even_b[p]), .prods(pp_he[p]));
      lane_bank #(.LANES(LANES)) u_ho (.scal(k[p][15:8]), .lanes(odd_b[p]),  .prods(pp_ho[p]));
    end
  endgenerate

  // both halves merge lane-wise; the two middle groups share one rank
  assign lane_even = pp_le[0] ^ pp_le[1];
  assign lane_mid  = pp_lo[0] ^ pp_lo[1] ^ pp_he[0] ^ pp_he[1];
  assign lane_odd  = pp_ho[0] ^ pp_ho[1];
  assign pp_all    = {pp_le, pp_lo, pp_he, pp_ho};

  rank_merge #(.LANES(LANES)) u_merge (
    .lane_even (lane_even),
    .lane_mid  (lane_mid),
    .lane_odd  (lane_odd),
    .sum       (sum_w)
  );

  generate
    if (REGISTERED) begin : g_reg
      logic [SUM_W-1:0] sum_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_w;
      end
      assign product = {{(DATA_W-SUM_W){1'b0}}, sum_q};
    end else begin : g_comb
      assign product = {{(DATA_W-SUM_W){1'b0}}, sum_w};
    end
  endgenerate
endmodule

// File: rtl/clmul16x64_pair_chk.sv
module clmul16x64_pair_chk #(
  parameter int WIDE_BYTES = 8,
  parameter bit REGISTERED = 1'b1,
  localparam int HALF_W  = 8*WIDE_BYTES,
  localparam int DATA_W  = 2*HALF_W,
  localparam int SUM_W   = HALF_W + 16,
  localparam int PP_ALL  = 8*(WIDE_BYTES/2)*16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       k_lo,
  input logic [15:0]       k_hi,
  input logic [DATA_W-1:0] data,
  input logic [DATA_W-1:0] product,
  input logic [PP_ALL-1:0] pp_all
);
  // serial model: walk the constant bits, add shifted data half
  function automatic logic [SUM_W-1:0] serial_mul(input logic [15:0] c,
                                                  input logic [HALF_W-1:0] d);
    logic [SUM_W-1:0] acc;
    acc = '0;
    for (int b = 0; b < 16; b++) if (c[b]) acc ^= SUM_W'(d) << b;
    return acc;
  endfunction

  logic [SUM_W-1:0] model;
  logic             pp_msb_any;
  always_comb begin
    model = serial_mul(k_lo, data[HALF_W-1:0]) ^ serial_mul(k_hi, data[DATA_W-1:HALF_W]);
    pp_msb_any = 1'b0;
    for (int j = 0; j < PP_ALL/16; j++) pp_msb_any |= pp_all[j*16+15];
  end

  a_r4_reset_clear: assert property (@(posedge clk) !rst_n |-> product == '0);
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    product[DATA_W-1:SUM_W] == '0);
  a_r8_top_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !product[SUM_W-1]);
  // R1: every 8x8 cell leaves the top bit of its 16-bit field clear
  a_r1_cell_msb: assert property (@(posedge clk) disable iff (!rst_n) !pp_msb_any);

  generate
    if (REGISTERED) begin : g_seq
      a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> product[SUM_W-1:0] == $past(model));
      a_r5_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
        ((k_lo == 16'h0 && k_hi == 16'h0) || data == '0) |=> product == '0);
      a_r6_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (k_lo == 16'h0001 && k_hi == 16'h0) |=>
        product[SUM_W-1:0] == SUM_W'($past(data[HALF_W-1:0])));
    end
  endgenerate
endmodule

bind clmul16x64_pair clmul16x64_pair_chk #(
  .WIDE_BYTES (WIDE_BYTES),
  .REGISTERED (REGISTERED)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .k_lo    (k_lo),
  .k_hi    (k_hi),
  .data    (data),
  .product (product),
  .pp_all  (pp_all)
);

// File: tb/sim_clmul16x64_pair.sv
`timescale 1ns/1ps
module sim_clmul16x64_pair;
  localparam int CLK_HALF = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [15:0]  k_lo, k_hi;
  logic [127:0] data;
  logic [127:0] product;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #CLK_HALF clk = ~clk;

  clmul16x64_pair u0 (
    .clk (clk), .rst_n (rst_n), .k_lo (k_lo), .k_hi (k_hi),
    .data (data), .product (product)
  );

  // walk the data bits, add the shifted constant
  function automatic logic [79:0] ref_mul(input logic [15:0] c, input logic [63:0] d);
    logic [79:0] acc;
    acc = '0;
    for (int j = 0; j < 64; j++) if (d[j]) acc ^= {64'h0, c} << j;
    return acc;
  endfunction

  function automatic logic [127:0] expect_of(input logic [15:0] lo, input logic [15:0] hi,
                                             input logic [127:0] d);
    return {48'h0, ref_mul(lo, d[63:0]) ^ ref_mul(hi, d[127:64])};
  endfunction

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic apply(input string req, input logic [15:0] lo, input logic [15:0] hi,
                       input logic [127:0] d);
    @(negedge clk);
    k_lo = lo; k_hi = hi; data = d;
    @(negedge clk);
    check(req, product, expect_of(lo, hi, d));
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [127:0] d, held;
    logic [15:0]  a, b;
    void'($urandom(32'd20251));
    rst_n = 1'b0; k_lo = 16'hffff; k_hi = 16'hffff; data = '1;
    repeat (3) @(negedge clk);
    check("R4 reset state", product, '0);
    rst_n = 1'b1;

    // R5 zero operands
    apply("R5 zero constants", 16'h0, 16'h0, rnd128());
    apply("R5 zero data", 16'hbeef, 16'h1234, '0);
    // R6 identity and byte shift
    d = rnd128();
    apply("R6 identity", 16'h0001, 16'h0000, d);
    check("R6 identity passes half", product, {64'h0, d[63:0]});
    apply("R6 byte shift", 16'h0100, 16'h0000, d);
    check("R6 shift by 8", product, {56'h0, d[63:0], 8'h0});
    // R8 top degree
    apply("R8 top degree", 16'h8000, 16'h0000, {64'h0, 64'h8000_0000_0000_0000});
    check("R8 bit 78 set", product, {49'h0, 1'b1, 78'h0});
    apply("R8 all ones", 16'hffff, 16'hffff, '1);
    check("R8 bit 79 clear", {127'h0, product[79]}, '0);
    // R7 halves independent
    d = rnd128();
    apply("R7 high constant zero", 16'ha5c3, 16'h0, d);
    check("R7 low half only", product, {48'h0, ref_mul(16'ha5c3, d[63:0])});
    apply("R7 low constant zero", 16'h0, 16'h3c5a, d);
    check("R7 high half only", product, {48'h0, ref_mul(16'h3c5a, d[127:64])});
    // R1 single-bit sweep of each constant byte
    for (int s = 0; s < 16; s++) apply("R1 single bit", 16'h1 << s, 16'h1 << (15 - s), rnd128());

    // R3 hold between edges
    apply("R3 load", 16'h1357, 16'h2468, rnd128());
    held = product;
    #2 k_lo = 16'hffff; k_hi = 16'h0f0f; data = rnd128();
    #2 check("R3 hold between edges", product, held);

    // R1 and R2 random
    for (int n = 0; n < 400; n++) begin
      a = 16'($urandom); b = 16'($urandom);
      apply("R1 random", a, b, rnd128());
      check("R2 upper zero", {80'h0, product[127:80]}, '0);
    end

    // R4 asynchronous reset mid-run
    apply("R1 before reset", 16'hffff, 16'h8001, rnd128());
    #2 rst_n = 1'b0;
    #1 check("R4 async clear", product, '0);
    @(posedge clk); #1 check("R4 held in reset", product, '0);
    @(negedge clk); rst_n = 1'b1;
    apply("R1 after reset", 16'h00ff, 16'hff00, rnd128());

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(2*CLK_HALF*200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R3 watchdog got=timeout exp=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule